// File: doc/BRIEF.md
# Serial Configuration Byte Store

This block models a tiny sixteen-byte configuration memory that a host reaches over three level-driven wires (a select, a serial clock and a serial data input) and one returned data bit. Everything runs on a fast system clock. The serial clock is only a sampled level: the block keeps its previous value and acts when it sees a low-to-high change while select is low. Nothing is buffered at the edge of the block. The pins are plain levels, so there is no valid/ready pairing and no back-pressure. The host paces every transfer through the serial clock it drives.

A transfer starts with one command byte, shifted in most significant bit first. The upper nibble is the operation: 0x5 reads and 0xA writes. The lower nibble is the byte address. Eight data bits follow, most significant first. A write commits each bit to the addressed byte on the edge that carries it. A read moves the matching stored bit to the output on each edge.

There are two resets. The power reset also clears the storage. The serial reset restores only the interface state.

Top module: `sercfg_store`

## Requirements
- R1: While `sel` is high the bit counter is held at zero, so a partly shifted command is dropped and the next transfer starts with a fresh command byte.
- R2: With `sel` low, a bit is taken from `sdi` only when `sclk` is seen high after being low at the previous system clock. A level held high for several cycles counts as one bit, and changes on `sdi` between edges have no effect.
- R3: The first eight bits enter the command register MSB first. Command bits [7:4] are the operation and bits [3:0] select one of sixteen bytes.
- R4: If bits [7:4] of a completed command are neither 0x5 nor 0xA, the counter goes back to zero. The bits that follow are then taken as a new command, and storage is not modified.
- R5: With operation 0xA, the eight following bits overwrite the addressed byte from bit 7 down to bit 0. Each bit is stored on its own edge, so bits already sent survive if `sel` is raised early.
- R6: With operation 0x5, on each of the eight following edges `sdo` takes the addressed byte's bit, from bit 7 down to bit 0. At all other times `sdo` holds its value.
- R7: After the sixteenth bit of a transfer the counter wraps to zero, so a further command may follow without raising `sel`.
- R8: The power reset `pwr_rst_n` clears all sixteen bytes to zero and also performs the serial reset.
- R9: The serial reset `rst_n` sets `sdo` to 1, the remembered clock level to 1, and the counter and command to zero. Stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Active-low power reset; clears the storage and the serial state |
| rst_n | input | 1 | Active-low serial reset; storage is kept |
| sel | input | 1 | Transfer select; high idles the interface |
| sclk | input | 1 | Serial clock level, sampled by `clk` |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (read bits) |

## Verification
The hardest state to reach from the pins is one where the counter has returned to zero with no `sel` pulse. This happens in two ways: after an illegal opcode, and after a full sixteen-bit transfer. From outside, that state can only be seen by what the following bits do. The stimulus therefore keeps `sel` low across an illegal command followed by a read, and across a write followed at once by a read of the same byte. It also raises `sel` part way through a write, then reads the byte back, to show that each bit was committed on its own edge.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 4'h5,
    OP_WRITE = 4'hA
  } op_e;

  function automatic logic op_legal(input logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction
endpackage

// File: rtl/sercfg_edge.sv
module sercfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  output logic rise
);
  logic prev_lvl;

  // remembered level follows the pin whether or not select is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b1;
    else        prev_lvl <= sclk;
  end

  assign rise = sclk & ~prev_lvl & ~sel;

  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sercfg_mem.sv
module sercfg_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int N_BYTES = 1 << ADDR_W,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic              wbit,
  output logic              rbit
);
  logic [DATA_W-1:0] store [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n)
        store[g] <= '0;
      else if (we && addr == ADDR_W'(g))
        store[g][bit_sel] <= wbit;
    end

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !(we && addr == ADDR_W'(g)) |=> $stable(store[g]));
  end

  assign rbit = store[addr][bit_sel];
endmodule

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int CMD_W = OP_W + ADDR_W,
  localparam int TOT   = CMD_W + DATA_W,
  localparam int CNT_W = $clog2(TOT),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rise,
  input  logic              sdi,
  input  logic              mem_rbit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BIT_W-1:0]  mem_bit,
  output logic              mem_wbit,
  output logic              sdo
);
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd;
  logic [CMD_W-1:0] cmd_next;
  logic [CNT_W-1:0] data_pos;
  logic [OP_W-1:0]  op;
  logic             in_cmd;
  logic             rd_step;

  assign in_cmd   = cnt < CNT_W'(CMD_W);
  assign cmd_next = {cmd[CMD_W-2:0], sdi};
  assign op       = cmd[CMD_W-1 -: OP_W];
  assign mem_addr = cmd[ADDR_W-1:0];
  assign data_pos = cnt - CNT_W'(CMD_W);
  assign mem_bit  = BIT_W'(DATA_W - 1) - data_pos[BIT_W-1:0];
  assign mem_wbit = sdi;
  assign mem_we   = rise & ~in_cmd & (op == OP_WRITE);
  assign rd_step  = rise & ~in_cmd & (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cmd <= '0;
      sdo <= 1'b1;
    end else if (sel) begin
      cnt <= '0;
    end else if (rise) begin
      if (in_cmd) begin
        cmd <= cmd_next;
        if (cnt == CNT_W'(CMD_W - 1) && !op_legal(cmd_next[CMD_W-1 -: OP_W]))
          cnt <= '0;
        else
          cnt <= cnt + 1'b1;
      end else begin
        cnt <= (cnt == CNT_W'(TOT - 1)) ? '0 : cnt + 1'b1;
        if (rd_step) sdo <= mem_rbit;
      end
    end
  end

  a_r1_select_idles: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> cnt == '0);
  a_r4_bad_opcode_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt == CNT_W'(CMD_W - 1) && !op_legal(cmd_next[CMD_W-1 -: OP_W])) |=> cnt == '0);
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt == CNT_W'(TOT - 1)) |=> cnt == '0);
  a_r6_sdo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_step |=> $stable(sdo));
  a_r5_no_write_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    in_cmd |-> !mem_we);
endmodule

// File: rtl/sercfg_store.sv
module sercfg_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              ser_rst_n;
  logic              rise;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BIT_W-1:0]  mem_bit;
  logic              mem_wbit;
  logic              mem_rbit;

  assign ser_rst_n = rst_n & pwr_rst_n;

  sercfg_edge u_edge (
    .clk  (clk),
    .rst_n(ser_rst_n),
    .sel  (sel),
    .sclk (sclk),
    .rise (rise)
  );

  sercfg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (ser_rst_n),
    .sel     (sel),
    .rise    (rise),
    .sdi     (sdi),
    .mem_rbit(mem_rbit),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .mem_bit (mem_bit),
    .mem_wbit(mem_wbit),
    .sdo     (sdo)
  );

  sercfg_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk      (clk),
    .pwr_rst_n(pwr_rst_n),
    .we       (mem_we),
    .addr     (mem_addr),
    .bit_sel  (mem_bit),
    .wbit     (mem_wbit),
    .rbit     (mem_rbit)
  );
endmodule

// File: tb/sercfg_store_bench.sv
module sercfg_store_bench;
  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sercfg_store u_sercfg_store (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
    .sel(sel), .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // vector: {cmd byte, data byte, expected byte}; cmd 0xA? writes, 0x5? reads
  localparam logic [23:0] VEC [12] = '{
    24'h5500_00, 24'hA3A5_00, 24'hA03C_00, 24'hAFFF_00,
    24'h5300_A5, 24'h5000_3C, 24'h5F00_FF, 24'hA35A_00,
    24'h5300_5A, 24'h5700_00, 24'hA781_00, 24'h5700_81
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one serial bit: edge seen at the posedge after sclk goes high; sdi flips while high (R2)
  task automatic send_bit(input logic b);
    @(negedge clk) begin sdi = b; sclk = 1'b0; end
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) sdi = ~b;
    @(negedge clk) sdi = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b0);
      v[i] = sdo;
    end
  endtask

  task automatic begin_xfer;
    @(negedge clk) begin sel = 1'b0; sclk = 1'b0; end
  endtask

  task automatic end_xfer;
    @(negedge clk) sel = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    begin_xfer; send_byte({4'hA, a}); send_byte(d); end_xfer;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    begin_xfer; send_byte({4'h5, a}); recv_byte(d); end_xfer;
  endtask

  logic [7:0] got;
  logic [7:0] held;

  initial begin
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R8 sdo after power reset", {7'd0, sdo}, 8'h01);

    // table walk (R3, R5, R6, R8 on untouched bytes)
    for (int k = 0; k < 12; k++) begin
      if (VEC[k][23:20] == 4'hA)
        do_write(VEC[k][19:16], VEC[k][15:8]);
      else begin
        do_read(VEC[k][19:16], got);
        chk("R6 table read", got, VEC[k][7:0]);
      end
    end

    // R6: sdo holds after a read while select is high and sclk toggles
    held = {7'd0, sdo};
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    chk("R6 sdo holds", {7'd0, sdo}, held);

    // R4: illegal opcode 0x3 then a read with select kept low
    begin_xfer; send_byte(8'h30); send_byte(8'h50); recv_byte(got); end_xfer;
    chk("R4 read after illegal command", got, 8'h3C);
    // R4: illegal 0xF3 followed by ones, storage at 3 untouched
    begin_xfer; send_byte(8'hF3); send_byte(8'hFF); end_xfer;
    do_read(4'h3, got);
    chk("R4 storage untouched", got, 8'h5A);

    // R7: write then read in one select-low window
    begin_xfer; send_byte(8'hA2); send_byte(8'h66);
    send_byte(8'h52); recv_byte(got); end_xfer;
    chk("R7 back-to-back", got, 8'h66);

    // R1: partial command then select high; next read is aligned
    begin_xfer; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); end_xfer;
    do_read(4'h0, got);
    chk("R1 partial command dropped", got, 8'h3C);

    // R5: partial write of three ones into byte 9
    begin_xfer; send_byte(8'hA9); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); end_xfer;
    do_read(4'h9, got);
    chk("R5 partial write kept", got, 8'hE0);

    // R2: long high level counts once; written with stretched first bit
    begin_xfer;
    @(negedge clk) begin sdi = 1'b1; sclk = 1'b0; end
    @(negedge clk) sclk = 1'b1;
    repeat (6) @(negedge clk) sdi = ~sdi;
    @(negedge clk) sdi = 1'b0;
    for (int i = 6; i >= 0; i--) send_bit(i[0]);
    // command bits were 1 then 0101010 = 0xAA: write byte 10
    send_byte(8'hC3); end_xfer;
    do_read(4'hA, got);
    chk("R2 one bit per rising edge", got, 8'hC3);

    // R9: serial reset with partial command and sclk high; storage kept
    begin_xfer; send_bit(1'b1); send_bit(1'b0);
    @(negedge clk) begin sclk = 1'b1; rst_n = 1'b0; end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R9 sdo after serial reset", {7'd0, sdo}, 8'h01);
    @(negedge clk) sclk = 1'b0;
    send_byte(8'h53); recv_byte(got); end_xfer;
    chk("R9 storage kept, counter cleared", got, 8'h5A);

    // R8: power reset clears storage
    @(negedge clk) pwr_rst_n = 1'b0;
    @(negedge clk) pwr_rst_n = 1'b1;
    do_read(4'h3, got);
    chk("R8 byte cleared", got, 8'h00);
    do_read(4'hF, got);
    chk("R8 top byte cleared", got, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule